// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank SDR SDRAM from power-on to a usable state. After reset it holds the command pins at NOP, keeps the clock enable high, and holds both byte-mask outputs high so the memory's data pins stay high-impedance. It then counts out a power-up pause of at least 200 µs, precharges every bank with one precharge-all command, writes a mode word given as a parameter, and issues a parameterized number of auto-refresh commands. A parameter places the refreshes either before or after the mode write. Once the wait after the last command runs out, it raises a done flag that stays high, and it drops the byte masks.

The clock period and every analog timing value are given in picoseconds. Each one becomes a cycle count by dividing by the clock period and rounding any remainder up. The sequencer is a single state machine with the following states:

- `S_POWERUP`, `S_PRECHARGE`, `S_WAIT_RP`, `S_REFRESH`, `S_WAIT_RC`, `S_LOAD_MODE`, `S_WAIT_MRD` and `S_DONE`.
- Transitions:
  - pause expired: POWERUP→PRECHARGE.
  - precharge settle: PRECHARGE/WAIT_RP→the first refresh or the mode load.
  - refresh settle: REFRESH/WAIT_RC→another refresh, the mode load, or DONE.
  - mode settle: LOAD_MODE/WAIT_MRD→the first refresh or DONE.

A command state skips its wait state when that wait is a single cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and in the cycles after it, the command pins show NOP, `sdram_cke` is high, both byte masks are high and `init_done` is low. `sdram_cke` stays high at all times.
- R2: Cycle 0 is the first cycle after reset is released. No command other than NOP appears before cycle N_PU = ceil(T_POWERUP_PS / CLK_PERIOD_PS).
- R3: The first command is precharge-all, issued in cycle N_PU, with address bit AP_BIT (10) high.
- R4: The load-mode command drives MODE_WORD on the address bus and zero on the bank bits.
- R5: Exactly REFRESH_COUNT auto-refresh commands are issued. With REF_AFTER_MRS=0 they all come before the load-mode command; with REF_AFTER_MRS=1 they all come after it.
- R6: Each command follows the previous one by exactly N_RP cycles (after precharge), N_RC cycles (after a refresh) or N_MRD cycles (after a load-mode). Every cycle in between is NOP.
- R7: Each of N_RP, N_RC and N_MRD equals the timing value divided by the clock period, with any fraction rounded up and a floor of 1. For example, 63 ns at 5 ns gives 13 and 60 ns gives 12.
- R8: `init_done` rises in the cycle the wait after the final command expires and then stays high. Both byte masks are high exactly while `init_done` is low.
- R9: Command encodings on {cs_n, ras_n, cas_n, we_n} are:
  - NOP = 0111
  - precharge = 0010
  - auto-refresh = 0001
  - load-mode = 0000
- R10: Asserting reset at any point of the sequence returns the block to the R1 state. After release, the full sequence runs again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdram_cke | output | 1 | Clock enable, held high |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_ba | output | BANK_W | Bank select |
| sdram_addr | output | ADDR_W | Address bus |
| sdram_dqm_lo | output | 1 | Lower byte mask |
| sdram_dqm_hi | output | 1 | Upper byte mask |
| init_done | output | 1 | Initialization complete |

## Verification
The assertions check the following on every cycle:
- no command before the power-up count completes;
- the minimum gap between any command and the one before it;
- the precharge-all address bit;
- the mode word on the bus;
- the refresh tally at the mode load and at completion;
- that done stays high;
- that the masks track done.

Only the bench's scenarios can show that the schedule lands on exactly the expected cycles under both refresh placements with rounded and exact timing values. The same holds for correct recovery when reset hits at a random point mid-sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Pin encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP       = 4'b0111,
        CMD_PRECHARGE = 4'b0010,
        CMD_REFRESH   = 4'b0001,
        CMD_LOAD_MODE = 4'b0000
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        S_POWERUP,
        S_PRECHARGE,
        S_WAIT_RP,
        S_REFRESH,
        S_WAIT_RC,
        S_LOAD_MODE,
        S_WAIT_MRD,
        S_DONE
    } init_state_e;

    // Whole cycles covering a duration, fraction rounded up, never below one
    function automatic int cycles_ceil(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter int                BANK_W    = 1,
    parameter int                AP_BIT    = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  sdram_cmd_e         cmd,
    output logic               cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BANK_W-1:0]  ba,
    output logic [ADDR_W-1:0]  addr
);

    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
        ba = '0;
        unique case (cmd)
            CMD_PRECHARGE: addr = ALL_BANKS;
            CMD_LOAD_MODE: addr = MODE_WORD;
            default:       addr = '0;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_PERIOD_PS = 5000,
    parameter int                T_POWERUP_PS  = 200_000_000,
    parameter int                T_RP_PS       = 20_000,
    parameter int                T_RC_PS       = 63_000,
    parameter int                T_MRD_PS      = 10_000,
    parameter int                REFRESH_COUNT = 2,
    parameter bit                REF_AFTER_MRS = 1'b0,
    parameter int                ADDR_W        = 11,
    parameter int                BANK_W        = 1,
    parameter int                AP_BIT        = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD     = 11'h030
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sdram_cke,
    output logic              sdram_cs_n,
    output logic              sdram_ras_n,
    output logic              sdram_cas_n,
    output logic              sdram_we_n,
    output logic [BANK_W-1:0] sdram_ba,
    output logic [ADDR_W-1:0] sdram_addr,
    output logic              sdram_dqm_lo,
    output logic              sdram_dqm_hi,
    output logic              init_done
);

    localparam int N_PU  = cycles_ceil(T_POWERUP_PS, CLK_PERIOD_PS);
    localparam int N_RP  = cycles_ceil(T_RP_PS, CLK_PERIOD_PS);
    localparam int N_RC  = cycles_ceil(T_RC_PS, CLK_PERIOD_PS);
    localparam int N_MRD = cycles_ceil(T_MRD_PS, CLK_PERIOD_PS);
    localparam int N_M1  = (N_RP > N_RC) ? N_RP : N_RC;
    localparam int N_M2  = (N_M1 > N_MRD) ? N_M1 : N_MRD;
    localparam int N_MAX = (N_M2 > N_PU) ? N_M2 : N_PU;
    localparam int CNT_W = $clog2(N_MAX + 1) + 1;
    localparam int REF_W = $clog2(REFRESH_COUNT + 1);

    init_state_e      state_q, state_d;
    init_state_e      after_rp, after_rc, after_mrd;
    sdram_cmd_e       cmd_sel;
    logic             mask_on;
    logic             done_flag;
    logic             t_load, t_expire;
    logic [CNT_W-1:0] t_val;
    logic [REF_W-1:0] ref_issued_q;
    logic [REF_W:0]   ref_now;
    logic             more_ref;

    init_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (N_PU)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    // Refresh tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_issued_q <= '0;
        end else if (state_q == S_REFRESH) begin
            ref_issued_q <= ref_issued_q + 1'b1;
        end
    end

    always_comb begin
        ref_now  = {1'b0, ref_issued_q} + (REF_W+1)'(state_q == S_REFRESH);
        more_ref = ref_now < (REF_W+1)'(REFRESH_COUNT);
    end

    // Refresh placement variant
    if (REF_AFTER_MRS) begin : g_ref_late
        assign after_rp  = S_LOAD_MODE;
        assign after_mrd = S_REFRESH;
        assign after_rc  = more_ref ? S_REFRESH : S_DONE;
    end else begin : g_ref_early
        assign after_rp  = S_REFRESH;
        assign after_mrd = S_DONE;
        assign after_rc  = more_ref ? S_REFRESH : S_LOAD_MODE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and wait loading
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            S_POWERUP: begin
                if (t_expire) state_d = S_PRECHARGE;
            end
            S_PRECHARGE: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(N_RP - 1);
                state_d = (N_RP > 1) ? S_WAIT_RP : after_rp;
            end
            S_WAIT_RP: begin
                if (t_expire) state_d = after_rp;
            end
            S_REFRESH: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(N_RC - 1);
                state_d = (N_RC > 1) ? S_WAIT_RC : after_rc;
            end
            S_WAIT_RC: begin
                if (t_expire) state_d = after_rc;
            end
            S_LOAD_MODE: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(N_MRD - 1);
                state_d = (N_MRD > 1) ? S_WAIT_MRD : after_mrd;
            end
            S_WAIT_MRD: begin
                if (t_expire) state_d = after_mrd;
            end
            S_DONE: begin
                state_d = S_DONE;
            end
        endcase
    end

    // Outputs per state
    always_comb begin
        cmd_sel   = CMD_NOP;
        mask_on   = 1'b1;
        done_flag = 1'b0;
        unique case (state_q)
            S_PRECHARGE: cmd_sel = CMD_PRECHARGE;
            S_REFRESH:   cmd_sel = CMD_REFRESH;
            S_LOAD_MODE: cmd_sel = CMD_LOAD_MODE;
            S_DONE: begin
                mask_on   = 1'b0;
                done_flag = 1'b1;
            end
            S_POWERUP, S_WAIT_RP, S_WAIT_RC, S_WAIT_MRD: cmd_sel = CMD_NOP;
        endcase
    end

    init_cmd_drive #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .AP_BIT    (AP_BIT),
        .MODE_WORD (MODE_WORD)
    ) u_drive (
        .cmd   (cmd_sel),
        .cs_n  (sdram_cs_n),
        .ras_n (sdram_ras_n),
        .cas_n (sdram_cas_n),
        .we_n  (sdram_we_n),
        .ba    (sdram_ba),
        .addr  (sdram_addr)
    );

    assign sdram_cke    = 1'b1;
    assign sdram_dqm_lo = mask_on;
    assign sdram_dqm_hi = mask_on;
    assign init_done    = done_flag;

    // Checking support: cycles since reset and since the last command
    logic [3:0]       pin_cmd;
    logic             cmd_seen;
    logic [CNT_W-1:0] since_rst_q, gap_q, gap_need_q;
    logic             seen_q;

    assign pin_cmd  = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};
    assign cmd_seen = (pin_cmd != CMD_NOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            gap_q       <= '0;
            gap_need_q  <= '0;
            seen_q      <= 1'b0;
        end else begin
            if (since_rst_q != CNT_W'(N_PU)) since_rst_q <= since_rst_q + 1'b1;
            if (cmd_seen) begin
                gap_q  <= CNT_W'(1);
                seen_q <= 1'b1;
                unique case (pin_cmd)
                    CMD_PRECHARGE: gap_need_q <= CNT_W'(N_RP);
                    CMD_REFRESH:   gap_need_q <= CNT_W'(N_RC);
                    default:       gap_need_q <= CNT_W'(N_MRD);
                endcase
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R2
    no_early_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |-> (since_rst_q == CNT_W'(N_PU)));

    // R6
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_seen && seen_q) |-> (gap_q >= gap_need_q));

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRECHARGE) |-> sdram_addr[AP_BIT]);

    // R4
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LOAD_MODE) |-> (sdram_addr == MODE_WORD && sdram_ba == '0));

    // R5
    ref_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LOAD_MODE) |->
            (ref_issued_q == (REF_AFTER_MRS ? REF_W'(0) : REF_W'(REFRESH_COUNT))));

    // R5
    ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ref_issued_q == REF_W'(REFRESH_COUNT)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    mask_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_dqm_lo == !init_done) && (sdram_dqm_hi == !init_done));

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

    function automatic int ceil_cyc(input int t_ps, input int p_ps);
        int c;
        c = (t_ps + p_ps - 1) / p_ps;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int PER_PS  = 5000;
    localparam int NPU     = ceil_cyc(200_000_000, PER_PS);
    localparam int WD_CYC  = 190_000;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cke_o  [2];
    logic [3:0]  cmd_o  [2];
    logic [0:0]  ba_o   [2];
    logic [10:0] addr_o [2];
    logic        dql_o  [2];
    logic        dqh_o  [2];
    logic        done_o [2];

    logic        cs0, ras0, cas0, we0, cs1, ras1, cas1, we1;

    sdram_init_seq #(
        .CLK_PERIOD_PS(PER_PS), .T_POWERUP_PS(200_000_000), .T_RP_PS(20_000),
        .T_RC_PS(63_000), .T_MRD_PS(10_000), .REFRESH_COUNT(2),
        .REF_AFTER_MRS(1'b0), .MODE_WORD(11'h030)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sdram_cke(cke_o[0]), .sdram_cs_n(cs0),
        .sdram_ras_n(ras0), .sdram_cas_n(cas0), .sdram_we_n(we0),
        .sdram_ba(ba_o[0]), .sdram_addr(addr_o[0]), .sdram_dqm_lo(dql_o[0]),
        .sdram_dqm_hi(dqh_o[0]), .init_done(done_o[0])
    );

    sdram_init_seq #(
        .CLK_PERIOD_PS(PER_PS), .T_POWERUP_PS(200_000_000), .T_RP_PS(15_000),
        .T_RC_PS(60_000), .T_MRD_PS(10_000), .REFRESH_COUNT(3),
        .REF_AFTER_MRS(1'b1), .MODE_WORD(11'h022)
    ) dut_alt (
        .clk(clk), .rst_n(rst_n), .sdram_cke(cke_o[1]), .sdram_cs_n(cs1),
        .sdram_ras_n(ras1), .sdram_cas_n(cas1), .sdram_we_n(we1),
        .sdram_ba(ba_o[1]), .sdram_addr(addr_o[1]), .sdram_dqm_lo(dql_o[1]),
        .sdram_dqm_hi(dqh_o[1]), .init_done(done_o[1])
    );

    assign cmd_o[0] = {cs0, ras0, cas0, we0};
    assign cmd_o[1] = {cs1, ras1, cas1, we1};

    int          nvec = 0;
    int          nfail = 0;
    int          ev_cyc [2][8];
    logic [3:0]  ev_cmd [2][8];
    int          nev [2];
    int          done_cyc [2];
    logic [10:0] mode_w [2];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected command schedule from the requirements (R5, R6, R7)
    task automatic build(input int i, input int rp_ps, input int rc_ps, input int mrd_ps,
                         input int nref, input bit late, input logic [10:0] mw);
        int t, nrp, nrc, nmrd;
        nrp  = ceil_cyc(rp_ps, PER_PS);
        nrc  = ceil_cyc(rc_ps, PER_PS);
        nmrd = ceil_cyc(mrd_ps, PER_PS);
        nev[i] = 0;
        t = NPU;
        ev_cyc[i][nev[i]] = t; ev_cmd[i][nev[i]] = C_PRE; nev[i]++; t += nrp;
        if (!late) begin
            for (int k = 0; k < nref; k++) begin
                ev_cyc[i][nev[i]] = t; ev_cmd[i][nev[i]] = C_REF; nev[i]++; t += nrc;
            end
        end
        ev_cyc[i][nev[i]] = t; ev_cmd[i][nev[i]] = C_MRS; nev[i]++; t += nmrd;
        if (late) begin
            for (int k = 0; k < nref; k++) begin
                ev_cyc[i][nev[i]] = t; ev_cmd[i][nev[i]] = C_REF; nev[i]++; t += nrc;
            end
        end
        done_cyc[i] = t;
        mode_w[i] = mw;
    endtask

    task automatic check_reset(input string req);
        for (int i = 0; i < 2; i++) begin
            chk(cmd_o[i] == C_NOP, req, cmd_o[i], C_NOP);
            chk(cke_o[i] == 1'b1, req, cke_o[i], 1);
            chk(dql_o[i] && dqh_o[i], req, {dql_o[i], dqh_o[i]}, 3);
            chk(done_o[i] == 1'b0, req, done_o[i], 0);
        end
    endtask

    task automatic check_cycle(input int cyc);
        for (int i = 0; i < 2; i++) begin
            logic [3:0] e;
            logic       pre_done;
            e = C_NOP;
            for (int k = 0; k < nev[i]; k++) if (ev_cyc[i][k] == cyc) e = ev_cmd[i][k];
            if (e == C_NOP) begin
                chk(cmd_o[i] == C_NOP, (cyc < NPU) ? "R2 early command" : "R6 gap not NOP",
                    cmd_o[i], e);
            end else begin
                chk(cmd_o[i] == e, "R5 R6 R7 R9 scheduled command", cmd_o[i], e);
            end
            if (e == C_PRE) chk(addr_o[i][10] == 1'b1, "R3 precharge-all bit", addr_o[i], 11'h400);
            if (e == C_MRS) chk(addr_o[i] == mode_w[i] && ba_o[i] == 1'b0, "R4 mode word",
                                addr_o[i], mode_w[i]);
            pre_done = (cyc < done_cyc[i]);
            chk(dql_o[i] == pre_done && dqh_o[i] == pre_done, "R8 byte masks",
                {dql_o[i], dqh_o[i]}, {pre_done, pre_done});
            chk(done_o[i] == !pre_done, "R8 done flag", done_o[i], !pre_done);
            chk(cke_o[i] == 1'b1, "R1 cke", cke_o[i], 1);
        end
    endtask

    task automatic run_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            #1;
            check_cycle(c);
            @(negedge clk);
        end
    endtask

    initial begin
        int seed_sink, run_len, cut, hold;
        seed_sink = $urandom(32'd2718);
        build(0, 20_000, 63_000, 10_000, 2, 1'b0, 11'h030);
        build(1, 15_000, 60_000, 10_000, 3, 1'b1, 11'h022);
        // R7: rounding of a fractional and an exact period
        chk(ceil_cyc(63_000, PER_PS) == 13, "R7 rounding up", ceil_cyc(63_000, PER_PS), 13);
        chk(ceil_cyc(60_000, PER_PS) == 12, "R7 exact division", ceil_cyc(60_000, PER_PS), 12);
        run_len = ((done_cyc[0] > done_cyc[1]) ? done_cyc[0] : done_cyc[1]) + 20;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check_reset("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(run_len);

        // R10: reset at a random point of the sequence
        cut = $urandom_range(run_len - 20, NPU - 4);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(cut);
        rst_n = 1'b0;
        #1 check_reset("R10 abort reset state");
        hold = $urandom_range(4, 1);
        repeat (hold) @(negedge clk);
        #1 check_reset("R10 held reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(run_len);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=%0d exp=0", WD_CYC);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule